// File: doc/BRIEF.md
# Wake-on-LAN Sleep Controller

This block holds a network controller in a low-power sleep state and decides when to wake it. Software writes 1 to the wake enable bit to arm the mode, and the block goes to sleep on the next clock. While asleep it watches the received byte stream for a magic packet: six 0xFF sync bytes followed directly by sixteen back-to-back copies of the station's 48-bit address. When a frame that holds one ends with a good frame check, the block fires a one-cycle wake pulse, leaves sleep and clears the enable bit. Software must arm the mode again after each wake.

Sleep ends in exactly three ways. A valid magic packet ends it. Software writing 0 to the enable bit ends it. A hardware or software reset ends it. No other frame type wakes the block. Frames that arrive while the block is awake are not examined.

The receive side is a valid/ready byte stream. `rx_ready` is always high, so the block never applies back-pressure. A beat is taken on every clock where `rx_valid` is high. Start and end markers and the frame-good flag are only read on such beats.

Top module: `wol_sleep_ctrl`

## Requirements
- R1: When `reg_wr_en` is high with `reg_wr_data`=1 and `sw_rst` is low, then after that clock edge `wol_enable`=1 and `sleeping`=1.
- R2: When `reg_wr_en` is high with `reg_wr_data`=0 and `sw_rst` is low, then after that edge `wol_enable`=0 and `sleeping`=0, and no wake pulse is produced.
- R3: While `hw_rst_n` is low (synchronous, active low), and on any edge where `sw_rst` is high, the block behaves the same way. It sets `sleeping`=0 and `wake_pulse`=0, loads `wol_enable` from `cfg_wol_preset`, and discards any partial match.
- R4: A magic packet is six bytes of 0xFF followed by sixteen copies of `station_mac`. Each copy is sent most significant byte first, bits 47:40 then 39:32 and so on. The magic packet may start at any byte offset inside a frame. The station address is assumed to contain no 0xFF byte.
- R5: `wake_pulse` is high for exactly one cycle: the cycle right after the accepted end-of-frame beat of a qualifying frame. In that same cycle `sleeping`=0 and `wol_enable`=0.
- R6: A frame wakes the block only if `rx_frame_good`=1 on its end-of-frame beat. A frame that holds a magic packet but ends bad leaves the block asleep.
- R7: A partial match that breaks restarts the search. If the byte that breaks it is 0xFF, that byte counts as the first sync byte of a new attempt. A run of more than six 0xFF bytes before the addresses still matches.
- R8: Frames received while `sleeping`=0 never cause a wake pulse.
- R9: A register write or `sw_rst` on the same edge as a qualifying end-of-frame beat takes priority, and no wake pulse fires. A write of 1 keeps the block asleep. A write of 0 or a reset leaves sleep.
- R10: `rx_ready` is always 1. Clocks with `rx_valid`=0 are ignored, whatever the marker and data inputs carry.
- R11: A start-of-frame beat restarts the search. A magic packet split across two frames does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, synchronous, active low |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| cfg_wol_preset | input | 1 | Value loaded into the enable bit on reset |
| reg_wr_en | input | 1 | Register write strobe for the enable bit |
| reg_wr_data | input | 1 | Value written to the enable bit |
| station_mac | input | 48 | Station address, static |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat accepted (always 1) |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_frame_good | input | 1 | Frame check result, read on the end-of-frame beat |
| sleeping | output | 1 | Block is in the sleep state |
| wake_pulse | output | 1 | One-cycle wake event |
| wol_enable | output | 1 | Live value of the enable bit |

## Verification
A wake decision and a software action can land on the same edge. The action is either a write to the enable bit or a software reset, arriving on the end-of-frame beat of a good frame that holds a magic packet. The bench provokes this by asserting the write or the reset during that final beat. It then checks that no pulse fires and that the sleep state follows the write value, or the reset. Randomised frames mix full, truncated and corrupted magic packets with idle bubbles and bad endings, and each result is compared with a brute-force search of the frame.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hFF;
  typedef enum logic {ST_AWAKE = 1'b0, ST_ASLEEP = 1'b1} sleep_st_e;
endpackage

// File: rtl/wol_magic_match.sv
module wol_magic_match
  import wol_pkg::*;
#(
  parameter int unsigned SYNC_LEN    = 6,
  parameter int unsigned ADDR_BYTES  = 6,
  parameter int unsigned ADDR_COPIES = 16
) (
  input  logic                         clk,
  input  logic                         clr,
  input  logic                         beat,
  input  logic                         sof,
  input  logic                         eof,
  input  logic [BYTE_W-1:0]            data,
  input  logic [ADDR_BYTES*BYTE_W-1:0] mac,
  output logic                         frame_magic
);
  localparam int unsigned MATCH_LEN = SYNC_LEN + ADDR_BYTES * ADDR_COPIES;
  localparam int unsigned POS_W     = $clog2(MATCH_LEN);
  localparam int unsigned IDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(MATCH_LEN - 1);
  localparam logic [POS_W-1:0] SYNC_POS = POS_W'(SYNC_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  logic [BYTE_W-1:0] mac_b [ADDR_BYTES];
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_mac_bytes
    assign mac_b[g] = mac[(ADDR_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  logic [POS_W-1:0] pos_q, pos_d, cur_pos;
  logic [IDX_W-1:0] idx_q, idx_d, cur_idx;
  logic             seen_q, seen_d, cur_seen;
  logic [BYTE_W-1:0] exp_byte;
  logic             in_sync, byte_hit, complete;

  // start-of-frame discards whatever the previous frame left behind
  assign cur_pos  = sof ? '0 : pos_q;
  assign cur_idx  = sof ? '0 : idx_q;
  assign cur_seen = sof ? 1'b0 : seen_q;

  assign in_sync  = cur_pos < SYNC_POS;
  assign exp_byte = in_sync ? SYNC_BYTE : mac_b[cur_idx];
  assign byte_hit = data == exp_byte;
  assign complete = byte_hit && (cur_pos == LAST_POS);
  assign frame_magic = beat && (cur_seen || complete);

  always_comb begin
    pos_d  = pos_q;
    idx_d  = idx_q;
    seen_d = seen_q;
    if (beat) begin
      seen_d = cur_seen || complete;
      if (complete) begin
        pos_d = '0;
        idx_d = '0;
      end else if (byte_hit) begin
        pos_d = cur_pos + 1'b1;
        idx_d = in_sync ? '0 : ((cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1);
      end else if (data == SYNC_BYTE) begin
        // a sync byte that breaks the address run opens a new attempt;
        // directly after the sync run it simply extends that run
        pos_d = (cur_pos == SYNC_POS) ? SYNC_POS : POS_W'(1);
        idx_d = '0;
      end else begin
        pos_d = '0;
        idx_d = '0;
      end
      if (eof) begin
        pos_d  = '0;
        idx_d  = '0;
        seen_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      pos_q  <= '0;
      idx_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      idx_q  <= idx_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/wol_sleep_fsm.sv
module wol_sleep_fsm
  import wol_pkg::*;
(
  input  logic clk,
  input  logic hw_rst_n,
  input  logic sw_rst,
  input  logic preset,
  input  logic wr_en,
  input  logic wr_data,
  input  logic wake_req,
  output logic asleep,
  output logic enable,
  output logic wake
);
  sleep_st_e st_q;
  logic      en_q, wake_q;

  always_ff @(posedge clk) begin
    if (!hw_rst_n || sw_rst) begin
      st_q   <= ST_AWAKE;
      en_q   <= preset;
      wake_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      if (wr_en) begin
        en_q <= wr_data;
        st_q <= wr_data ? ST_ASLEEP : ST_AWAKE;
      end else if (st_q == ST_ASLEEP && wake_req) begin
        wake_q <= 1'b1;
        en_q   <= 1'b0;
        st_q   <= ST_AWAKE;
      end
    end
  end

  assign asleep = st_q == ST_ASLEEP;
  assign enable = en_q;
  assign wake   = wake_q;
endmodule

// File: rtl/wol_sleep_ctrl.sv
module wol_sleep_ctrl
  import wol_pkg::*;
#(
  parameter int unsigned SYNC_LEN    = 6,
  parameter int unsigned ADDR_BYTES  = 6,
  parameter int unsigned ADDR_COPIES = 16
) (
  input  logic                         clk,
  input  logic                         hw_rst_n,
  input  logic                         sw_rst,
  input  logic                         cfg_wol_preset,
  input  logic                         reg_wr_en,
  input  logic                         reg_wr_data,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_mac,
  input  logic                         rx_valid,
  output logic                         rx_ready,
  input  logic [BYTE_W-1:0]            rx_data,
  input  logic                         rx_sof,
  input  logic                         rx_eof,
  input  logic                         rx_frame_good,
  output logic                         sleeping,
  output logic                         wake_pulse,
  output logic                         wol_enable
);
  logic frame_magic, wake_req, det_clr;

  assign rx_ready = 1'b1;
  assign det_clr  = !hw_rst_n || sw_rst || !sleeping;
  assign wake_req = frame_magic && rx_eof && rx_frame_good;

  wol_magic_match #(
    .SYNC_LEN(SYNC_LEN), .ADDR_BYTES(ADDR_BYTES), .ADDR_COPIES(ADDR_COPIES)
  ) u_match (
    .clk(clk), .clr(det_clr), .beat(rx_valid), .sof(rx_sof), .eof(rx_eof),
    .data(rx_data), .mac(station_mac), .frame_magic(frame_magic)
  );

  wol_sleep_fsm u_fsm (
    .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .preset(cfg_wol_preset),
    .wr_en(reg_wr_en), .wr_data(reg_wr_data), .wake_req(wake_req),
    .asleep(sleeping), .enable(wol_enable), .wake(wake_pulse)
  );
endmodule

// File: rtl/wol_sleep_ctrl_chk.sv
module wol_sleep_ctrl_chk (
  input logic clk,
  input logic hw_rst_n,
  input logic sw_rst,
  input logic reg_wr_en,
  input logic reg_wr_data,
  input logic rx_valid,
  input logic rx_eof,
  input logic rx_frame_good,
  input logic sleeping,
  input logic wake_pulse,
  input logic wol_enable
);
  p_write_one_sleeps_r1: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (reg_wr_en && reg_wr_data && !sw_rst) |=> (sleeping && wol_enable));

  p_write_zero_wakes_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (reg_wr_en && !reg_wr_data && !sw_rst) |=> (!sleeping && !wol_enable && !wake_pulse));

  p_sw_reset_exits_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_rst |=> (!sleeping && !wake_pulse));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    wake_pulse |=> !wake_pulse);

  p_pulse_clears_mode_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    wake_pulse |-> (!sleeping && !wol_enable));

  p_bad_frame_stays_r6: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sleeping && rx_valid && rx_eof && !rx_frame_good && !reg_wr_en && !sw_rst)
      |=> (sleeping && !wake_pulse));

  p_awake_no_wake_r8: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !sleeping |=> !wake_pulse);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!hw_rst_n)
    reg_wr_en |=> !wake_pulse);

  p_sleep_needs_enable_r1: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sleeping |-> wol_enable);
endmodule

bind wol_sleep_ctrl wol_sleep_ctrl_chk u_chk (.*);

// File: tb/sim_wol_sleep_ctrl.sv
module sim_wol_sleep_ctrl;
  logic        clk = 1'b0;
  logic        hw_rst_n = 1'b0, sw_rst = 1'b0, cfg_wol_preset = 1'b1;
  logic        reg_wr_en = 1'b0, reg_wr_data = 1'b0;
  logic [47:0] station_mac;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_frame_good = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready, sleeping, wake_pulse, wol_enable;
  int          n_checks = 0, n_errors = 0;
  logic [7:0]  fq[$];

  always #10 clk = ~clk;

  wol_sleep_ctrl u0 (
    .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .cfg_wol_preset(cfg_wol_preset),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .station_mac(station_mac),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_frame_good(rx_frame_good), .sleeping(sleeping),
    .wake_pulse(wake_pulse), .wol_enable(wol_enable)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic w, input logic s, input logic e);
    chk(req, "wake_pulse", {7'd0, wake_pulse}, {7'd0, w});
    chk(req, "sleeping", {7'd0, sleeping}, {7'd0, s});
    chk(req, "wol_enable", {7'd0, wol_enable}, {7'd0, e});
  endtask

  function automatic logic [7:0] mac_byte(input int k);
    return 8'((station_mac >> (8 * (5 - k))) & 48'hFF);
  endfunction

  function automatic bit ref_magic(input logic [7:0] q[$]);
    for (int s = 0; s + 102 <= q.size(); s++) begin
      bit ok = 1'b1;
      for (int k = 0; k < 102; k++) begin
        logic [7:0] e = (k < 6) ? 8'hFF : mac_byte((k - 6) % 6);
        if (q[s+k] !== e) ok = 1'b0;
      end
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic push_sync(input int n);
    for (int i = 0; i < n; i++) fq.push_back(8'hFF);
  endtask

  task automatic push_macs(input int n);
    for (int c = 0; c < n; c++)
      for (int k = 0; k < 6; k++) fq.push_back(mac_byte(k));
  endtask

  task automatic push_rand(input int n);
    for (int i = 0; i < n; i++)
      fq.push_back(($urandom % 8 == 0) ? 8'hFF : 8'($urandom % 255));
  endtask

  task automatic wr(input logic v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // sends fq as one frame; ends at the negedge right after the last beat is taken
  task automatic send(input logic good, input bit bubbles, input int act_last);
    for (int i = 0; i < fq.size(); i++) begin
      if (bubbles && ($urandom % 5 == 0)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'($urandom); rx_eof = 1'($urandom);
        rx_frame_good = 1'($urandom); rx_data = 8'hFF;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fq[i];
      rx_sof = (i == 0); rx_eof = (i == fq.size() - 1);
      rx_frame_good = (i == fq.size() - 1) ? good : 1'($urandom);
      if (i == fq.size() - 1) begin
        if (act_last == 1) begin reg_wr_en = 1'b1; reg_wr_data = 1'b1; end
        if (act_last == 2) begin reg_wr_en = 1'b1; reg_wr_data = 1'b0; end
        if (act_last == 3) sw_rst = 1'b1;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    reg_wr_en = 1'b0; sw_rst = 1'b0;
  endtask

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_init = $urandom(32'h0B0E_5EED);
    for (int k = 0; k < 6; k++) station_mac[47-8*k -: 8] = 8'($urandom % 255);
    repeat (3) @(negedge clk);
    // R3 / R10: reset state
    chk_state("R3", 1'b0, 1'b0, 1'b1);
    chk("R10", "rx_ready", {7'd0, rx_ready}, 8'd1);
    hw_rst_n = 1'b1;
    @(negedge clk);
    chk_state("R3", 1'b0, 1'b0, 1'b1);

    // R1
    wr(1'b1);
    chk_state("R1", 1'b0, 1'b1, 1'b1);

    // R4 / R7: seven sync bytes then the address copies, with bubbles
    fq = {}; push_rand(9); push_sync(7); push_macs(16); push_rand(4);
    send(1'b1, 1'b1, 0);
    chk_state("R4", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5", "wake_pulse after one cycle", {7'd0, wake_pulse}, 8'd0);

    // R8: awake frame ignored
    fq = {}; push_sync(6); push_macs(16);
    send(1'b1, 1'b0, 0);
    chk_state("R8", 1'b0, 1'b0, 1'b0);

    // R6: bad frame
    wr(1'b1);
    fq = {}; push_rand(3); push_sync(6); push_macs(16);
    send(1'b0, 1'b0, 0);
    chk_state("R6", 1'b0, 1'b1, 1'b1);

    // R11: magic split across two frames
    fq = {}; push_sync(6); push_macs(8);
    send(1'b1, 1'b0, 0);
    fq = {}; push_macs(8); push_rand(2);
    send(1'b1, 1'b0, 0);
    chk_state("R11", 1'b0, 1'b1, 1'b1);

    // R7: broken run restarted by a sync byte
    fq = {}; push_sync(6); push_macs(3); fq.push_back(mac_byte(0));
    push_sync(6); push_macs(16);
    send(1'b1, 1'b0, 0);
    chk_state("R7", 1'b1, 1'b0, 1'b0);

    // R9: write 1 on the qualifying beat
    wr(1'b1);
    fq = {}; push_sync(6); push_macs(16);
    send(1'b1, 1'b0, 1);
    chk_state("R9", 1'b0, 1'b1, 1'b1);
    // R9: write 0 on the qualifying beat
    send(1'b1, 1'b0, 2);
    chk_state("R9", 1'b0, 1'b0, 1'b0);
    // R9: software reset on the qualifying beat
    wr(1'b1);
    cfg_wol_preset = 1'b0;
    send(1'b1, 1'b0, 3);
    chk_state("R9", 1'b0, 1'b0, 1'b0);

    // R2
    wr(1'b1);
    wr(1'b0);
    chk_state("R2", 1'b0, 1'b0, 1'b0);

    // R3: hardware reset while asleep loads the preset
    wr(1'b1);
    cfg_wol_preset = 1'b1;
    hw_rst_n = 1'b0;
    @(negedge clk);
    hw_rst_n = 1'b1;
    chk_state("R3", 1'b0, 1'b0, 1'b1);
    // R3: software reset with preset 0
    wr(1'b1);
    cfg_wol_preset = 1'b0;
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    chk_state("R3", 1'b0, 1'b0, 1'b0);

    // random frames against the brute-force reference
    for (int it = 0; it < 60; it++) begin
      int kind = int'($urandom % 4);
      logic good = ($urandom % 4) != 0;
      bit exp_w;
      if (!sleeping) wr(1'b1);
      fq = {}; push_rand(int'($urandom % 40) + 1);
      if (kind == 1) begin push_sync(6 + int'($urandom % 2)); push_macs(16); end
      if (kind == 2) begin push_sync(6); push_macs(int'($urandom % 16)); end
      if (kind == 3) begin
        int at;
        push_sync(6); push_macs(16);
        at = fq.size() - 1 - int'($urandom % 96);
        fq[at] = fq[at] ^ 8'h5A;
      end
      push_rand(int'($urandom % 20));
      exp_w = good && ref_magic(fq);
      send(good, 1'b1, 0);
      chk_state(exp_w ? "R4" : "R6", exp_w, !exp_w, !exp_w);
      @(negedge clk);
      chk("R5", "pulse width", {7'd0, wake_pulse}, 8'd0);
    end

    finish_run();
  end
endmodule